// File: doc/BRIEF.md
# Dual-Port Contention Arbiter with Master/Slave Cascading

This block sits beside a two-port memory array and watches both request ports. When both ports are enabled and present the same address, it settles which side owns the location and asserts an active-low busy flag toward the other side. While busy is held, the losing side's write strobe is suppressed, so only the owner can modify the contested word. The memory array is not part of the block.

A mode input selects one of two roles. In master mode the block runs its own arbitration and presents the outcome on its busy outputs. In slave mode the internal arbitration is idle. The busy outputs then repeat busy values imported from a master device, so several devices placed side by side to widen the word all agree on the same winner. Because the imported busy can change while a slave port is trying to write, a slave port stays write-inhibited for a fixed number of clock cycles after each change of its imported busy.

The arbitration state machine has four states. ST_IDLE means no contention. ST_SETTLE covers the delay between detecting contention and asserting busy. ST_GRANT_L means the left side owns the location and the right side sees busy. ST_GRANT_R is the mirror case. The transitions are:
- idle-to-settle: contention appears and the delay is longer than one cycle.
- idle-to-grant: contention appears and the delay is one cycle.
- settle-count: contention persists and the delay has not yet elapsed.
- settle-to-grant: the delay elapses.
- settle-abort: contention ends before busy asserts.
- grant-hold: contention persists.
- grant-release: contention ends.
- slave-park: the mode input is low, which forces ST_IDLE.

Top module: `dp_clash_arbiter`

## Requirements
- R1: After reset, both busy outputs are high (inactive) and both write-inhibit outputs are low. A write pass output is high only when its port has chip enable low, write strobe low and inhibit low.
- R2: In master mode there is no contention unless both chip enables are low and the two addresses are equal. Without contention, both busy outputs stay high and both inhibits stay low.
- R3: In master mode, once contention is present, busy asserts on the BUSY_DLY-th rising clock edge counted from the first edge that samples the contention. It is not asserted earlier. If contention ends before that edge, busy does not assert.
- R4: In master mode, the port whose chip enable went low on an earlier clock edge wins. If both enables fall on the same edge, the left port wins. Only the losing port receives busy.
- R5: In master mode, busy returns high on the first clock edge that samples the end of contention.
- R6: While contention continues, the granted winner never changes, and the two busy outputs are never low together.
- R7: In master mode, a port's write inhibit equals its busy being active, and its write pass output is low whenever its busy is low.
- R8: The mode input high selects master and low selects slave. In slave mode, each busy output follows its imported busy input with no clock delay, and internal arbitration has no effect. In master mode, the imported busy inputs have no effect.
- R9: In slave mode, a port is write-inhibited while its imported busy is low. The inhibit also covers the cycle in which that input changes and the following SETTLE_CYC clock edges. After the SETTLE_CYC-th edge it clears unless the imported busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_sel | input | 1 | 1 = master (arbitrate internally), 0 = slave (import busy) |
| ce_l_n | input | 1 | Left chip enable, active low |
| addr_l | input | ADDR_W | Left address |
| wr_l_n | input | 1 | Left write strobe, active low |
| ce_r_n | input | 1 | Right chip enable, active low |
| addr_r | input | ADDR_W | Right address |
| wr_r_n | input | 1 | Right write strobe, active low |
| busy_in_l_n | input | 1 | Imported busy for the left port (slave mode), active low |
| busy_in_r_n | input | 1 | Imported busy for the right port (slave mode), active low |
| busy_l_n | output | 1 | Busy toward the left port, active low |
| busy_r_n | output | 1 | Busy toward the right port, active low |
| wr_inh_l | output | 1 | Left write inhibit |
| wr_inh_r | output | 1 | Right write inhibit |
| wr_pass_l | output | 1 | Left write strobe after suppression, active high |
| wr_pass_r | output | 1 | Right write strobe after suppression, active high |

## Verification
Every pair of left and right addresses in a three-bit configuration is applied with both enables falling on the same edge. Equal pairs must produce a left win after exactly the configured delay, and unequal pairs must produce no busy, which separates address compare from ordering. Staggered enables in both orders, and a late address change that creates a match, show that seniority rather than the left-side tie rule picks the winner. A match withdrawn during the delay must never reach busy. In slave mode, pulses on each imported busy line measure the write-hold window edge by edge, and also show that a same-address clash produces no internal busy in slave mode and that imported busy is ignored in master mode.

// File: rtl/dpca_pkg.sv
package dpca_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETTLE  = 2'd1,
        ST_GRANT_L = 2'd2,
        ST_GRANT_R = 2'd3
    } arb_state_e;

    typedef enum logic {
        SIDE_L = 1'b0,
        SIDE_R = 1'b1
    } side_e;

endpackage

// File: rtl/dpca_clash_detect.sv
module dpca_clash_detect
    import dpca_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_l_n,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic              ce_r_n,
    input  logic [ADDR_W-1:0] addr_r,
    output logic              clash,
    output side_e             first_side
);

    logic  en_l, en_r;
    logic  was_l_q, was_r_q;
    side_e first_q;

    assign en_l  = !ce_l_n;
    assign en_r  = !ce_r_n;
    assign clash = en_l && en_r && (addr_l == addr_r);

    // Seniority: a lone enabled port becomes senior; a simultaneous start favours left.
    always_comb begin
        first_side = first_q;
        if (en_l && !en_r) begin
            first_side = SIDE_L;
        end else if (en_r && !en_l) begin
            first_side = SIDE_R;
        end else if (en_l && en_r && !was_l_q && !was_r_q) begin
            first_side = SIDE_L;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            was_l_q <= 1'b0;
            was_r_q <= 1'b0;
            first_q <= SIDE_L;
        end else begin
            was_l_q <= en_l;
            was_r_q <= en_r;
            first_q <= first_side;
        end
    end

    assert_tie_goes_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_l && en_r && $past(ce_l_n) && $past(ce_r_n)) |-> (first_side == SIDE_L));

endmodule

// File: rtl/dpca_arb_fsm.sv
module dpca_arb_fsm
    import dpca_pkg::*;
#(
    parameter int BUSY_DLY = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  master,
    input  logic  clash,
    input  side_e first_side,
    output logic  block_l,
    output logic  block_r
);

    localparam int CW = (BUSY_DLY < 2) ? 1 : $clog2(BUSY_DLY + 1);
    localparam logic [CW-1:0] LAST = CW'(BUSY_DLY - 1);

    arb_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    side_e win_q, win_d;

    function automatic arb_state_e grant_of(input side_e s);
        return (s == SIDE_L) ? ST_GRANT_L : ST_GRANT_R;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            win_q   <= SIDE_L;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            win_q   <= win_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        win_d   = win_q;
        if (!master) begin
            state_d = ST_IDLE;                       // slave-park
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (clash) begin
                        win_d = first_side;
                        if (BUSY_DLY <= 1) begin
                            state_d = grant_of(first_side);   // idle-to-grant
                        end else begin
                            state_d = ST_SETTLE;              // idle-to-settle
                            cnt_d   = CW'(1);
                        end
                    end
                end
                ST_SETTLE: begin
                    if (!clash) begin
                        state_d = ST_IDLE;                    // settle-abort
                        cnt_d   = '0;
                    end else if (cnt_q == LAST) begin
                        state_d = grant_of(win_q);            // settle-to-grant
                    end else begin
                        cnt_d = cnt_q + CW'(1);               // settle-count
                    end
                end
                ST_GRANT_L, ST_GRANT_R: begin
                    if (!clash) begin
                        state_d = ST_IDLE;                    // grant-release
                        cnt_d   = '0;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        block_l = 1'b0;
        block_r = 1'b0;
        unique case (state_q)
            ST_GRANT_L: block_r = 1'b1;
            ST_GRANT_R: block_l = 1'b1;
            ST_IDLE, ST_SETTLE: ;
            default: ;
        endcase
    end

    assert_grant_needs_clash_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GRANT_L || state_q == ST_GRANT_R) |-> $past(clash));

    assert_winner_kept_L_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GRANT_L) |=> (state_q != ST_GRANT_R));

    assert_winner_kept_R_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GRANT_R) |=> (state_q != ST_GRANT_L));

    assert_no_early_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_IDLE && BUSY_DLY > 1) |-> (state_q != ST_GRANT_L && state_q != ST_GRANT_R));

endmodule

// File: rtl/dpca_slave_settle.sv
module dpca_slave_settle #(
    parameter int SETTLE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic busy_in_n,
    output logic hold
);

    localparam int SW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);
    localparam logic [SW-1:0] LOAD = SW'(SETTLE_CYC - 1);

    logic          prev_q;
    logic          moved;
    logic [SW-1:0] cnt_q;

    assign moved = (busy_in_n != prev_q);
    assign hold  = enable && (!busy_in_n || moved || (cnt_q != '0));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            cnt_q  <= '0;
        end else begin
            prev_q <= busy_in_n;
            if (!enable) begin
                cnt_q <= '0;
            end else if (moved) begin
                cnt_q <= LOAD;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - SW'(1);
            end
        end
    end

    assert_hold_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && busy_in_n != $past(busy_in_n)) |-> hold);

endmodule

// File: rtl/dp_clash_arbiter.sv
module dp_clash_arbiter
    import dpca_pkg::*;
#(
    parameter int ADDR_W     = 14,
    parameter int BUSY_DLY   = 2,
    parameter int SETTLE_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_sel,
    input  logic              ce_l_n,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic              wr_l_n,
    input  logic              ce_r_n,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic              wr_r_n,
    input  logic              busy_in_l_n,
    input  logic              busy_in_r_n,
    output logic              busy_l_n,
    output logic              busy_r_n,
    output logic              wr_inh_l,
    output logic              wr_inh_r,
    output logic              wr_pass_l,
    output logic              wr_pass_r
);

    localparam int NPORT = 2;

    logic  clash;
    side_e first_side;
    logic  blk_l, blk_r;

    logic [NPORT-1:0] imp_n, hold, own_blk, inh, ce_n, wr_n, busy_n, pass;

    dpca_clash_detect #(.ADDR_W(ADDR_W)) u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_l_n     (ce_l_n),
        .addr_l     (addr_l),
        .ce_r_n     (ce_r_n),
        .addr_r     (addr_r),
        .clash      (clash),
        .first_side (first_side)
    );

    dpca_arb_fsm #(.BUSY_DLY(BUSY_DLY)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .master     (master_sel),
        .clash      (clash),
        .first_side (first_side),
        .block_l    (blk_l),
        .block_r    (blk_r)
    );

    assign imp_n   = {busy_in_r_n, busy_in_l_n};
    assign own_blk = {blk_r, blk_l};
    assign ce_n    = {ce_r_n, ce_l_n};
    assign wr_n    = {wr_r_n, wr_l_n};

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dpca_slave_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
            .clk       (clk),
            .rst_n     (rst_n),
            .enable    (!master_sel),
            .busy_in_n (imp_n[p]),
            .hold      (hold[p])
        );
        assign busy_n[p] = master_sel ? !own_blk[p] : imp_n[p];
        assign inh[p]    = master_sel ? own_blk[p] : hold[p];
        assign pass[p]   = !ce_n[p] && !wr_n[p] && !inh[p];
    end

    assign busy_l_n  = busy_n[0];
    assign busy_r_n  = busy_n[1];
    assign wr_inh_l  = inh[0];
    assign wr_inh_r  = inh[1];
    assign wr_pass_l = pass[0];
    assign wr_pass_r = pass[1];

    assert_busy_blocks_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && (!busy_l_n || !busy_r_n)) |-> !(wr_pass_l && !busy_l_n) && !(wr_pass_r && !busy_r_n));

    assert_single_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        master_sel |-> !(!busy_l_n && !busy_r_n));

    assert_slave_no_pass_under_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_sel && !busy_in_l_n) |-> !wr_pass_l);

endmodule

// File: tb/test_dp_clash_arbiter.sv
module test_dp_clash_arbiter;

    localparam int AW = 3;
    localparam int BD = 2;
    localparam int SC = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_sel = 1'b1;
    logic ce_l_n = 1'b1, ce_r_n = 1'b1;
    logic wr_l_n = 1'b0, wr_r_n = 1'b0;
    logic [AW-1:0] addr_l = '0, addr_r = '0;
    logic busy_in_l_n = 1'b1, busy_in_r_n = 1'b1;
    logic busy_l_n, busy_r_n, wr_inh_l, wr_inh_r, wr_pass_l, wr_pass_r;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dp_clash_arbiter #(.ADDR_W(AW), .BUSY_DLY(BD), .SETTLE_CYC(SC)) i_dp_clash_arbiter (
        .clk(clk), .rst_n(rst_n), .master_sel(master_sel),
        .ce_l_n(ce_l_n), .addr_l(addr_l), .wr_l_n(wr_l_n),
        .ce_r_n(ce_r_n), .addr_r(addr_r), .wr_r_n(wr_r_n),
        .busy_in_l_n(busy_in_l_n), .busy_in_r_n(busy_in_r_n),
        .busy_l_n(busy_l_n), .busy_r_n(busy_r_n),
        .wr_inh_l(wr_inh_l), .wr_inh_r(wr_inh_r),
        .wr_pass_l(wr_pass_l), .wr_pass_r(wr_pass_r)
    );

    // Observation order: busy_l_n, busy_r_n, wr_inh_l, wr_inh_r, wr_pass_l, wr_pass_r
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic expect6(input string req, input logic [5:0] exp);
        logic [5:0] act;
        #1;
        act = {busy_l_n, busy_r_n, wr_inh_l, wr_inh_r, wr_pass_l, wr_pass_r};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_both();
        ce_l_n = 1'b1;
        ce_r_n = 1'b1;
        tick();
        tick();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick();
        tick();
        rst_n = 1'b1;
        expect6("R1 reset", 6'b110000);
        tick();

        // R2/R3/R4: every address pair, enables falling together
        for (int a = 0; a < (1 << AW); a++) begin
            for (int b = 0; b < (1 << AW); b++) begin
                idle_both();
                addr_l = AW'(a);
                addr_r = AW'(b);
                ce_l_n = 1'b0;
                ce_r_n = 1'b0;
                expect6("R3 no busy before edge", 6'b110011);
                for (int e = 1; e < BD; e++) begin
                    tick();
                    expect6("R3 no busy before delay", 6'b110011);
                end
                tick();
                if (a == b) expect6("R4 tie left wins", 6'b100110);
                else        expect6("R2 differing addresses", 6'b110011);
                tick();
                if (a == b) expect6("R6 winner held", 6'b100110);
                else        expect6("R2 differing addresses held", 6'b110011);
                ce_l_n = 1'b1;
                ce_r_n = 1'b1;
                tick();
                expect6("R5 release", 6'b110000);
            end
        end

        // R2: one side enabled, equal address
        idle_both();
        addr_l = 3'd4; addr_r = 3'd4; ce_l_n = 1'b0;
        tick(); tick(); tick();
        expect6("R2 single enable", 6'b110010);

        // R4: left senior
        ce_r_n = 1'b0;
        tick(); tick();
        expect6("R4 left earlier wins", 6'b100110);
        ce_l_n = 1'b1;
        tick();
        expect6("R5 release on winner leaving", 6'b110001);

        // R4: right senior
        idle_both();
        addr_l = 3'd6; addr_r = 3'd6; ce_r_n = 1'b0;
        tick();
        ce_l_n = 1'b0;
        tick(); tick();
        expect6("R4 right earlier wins", 6'b011001);
        expect6("R7 loser write suppressed", 6'b011001);
        ce_r_n = 1'b1;
        tick();
        expect6("R5 release right", 6'b110010);

        // R4: match created by address change, right enabled earlier
        idle_both();
        addr_r = 3'd2; ce_r_n = 1'b0;
        tick();
        addr_l = 3'd3; ce_l_n = 1'b0;
        tick(); tick();
        expect6("R2 both enabled no match", 6'b110011);
        addr_l = 3'd2;
        tick(); tick();
        expect6("R4 senior by enable after address change", 6'b011001);
        tick();
        expect6("R6 winner kept", 6'b011001);

        // R3: contention withdrawn before the delay elapses
        idle_both();
        addr_l = 3'd1; addr_r = 3'd1; ce_l_n = 1'b0; ce_r_n = 1'b0;
        tick();
        addr_r = 3'd5;
        tick();
        expect6("R3 withdrawn match no busy", 6'b110011);
        tick();
        expect6("R3 withdrawn match stays clear", 6'b110011);

        // R7: loser with write strobe high shows no pass either way
        idle_both();
        addr_l = 3'd7; addr_r = 3'd7; ce_l_n = 1'b0; ce_r_n = 1'b0; wr_r_n = 1'b1;
        tick(); tick();
        expect6("R7 inhibit follows busy", 6'b100110);
        wr_r_n = 1'b0;

        // R8: imported busy ignored in master mode
        idle_both();
        busy_in_l_n = 1'b0;
        busy_in_r_n = 1'b0;
        tick();
        expect6("R8 master ignores imported busy", 6'b110000);
        busy_in_l_n = 1'b1;
        busy_in_r_n = 1'b1;
        tick();

        // R8/R9: slave mode
        master_sel = 1'b0;
        addr_l = 3'd3; addr_r = 3'd3; ce_l_n = 1'b0; ce_r_n = 1'b0;
        tick(); tick(); tick();
        expect6("R8 slave no internal arbitration", 6'b110011);
        busy_in_l_n = 1'b0;
        expect6("R8 slave busy follows input", 6'b011001);
        tick(); tick();
        expect6("R9 inhibit while imported busy", 6'b011001);
        busy_in_l_n = 1'b1;
        expect6("R9 inhibit on release cycle", 6'b111001);
        for (int e = 1; e < SC; e++) begin
            tick();
            expect6("R9 inhibit within settle window", 6'b111001);
        end
        tick();
        expect6("R9 settle window over", 6'b110011);

        busy_in_r_n = 1'b0;
        expect6("R8 slave right busy follows input", 6'b100110);
        tick();
        busy_in_r_n = 1'b1;
        for (int e = 0; e < SC; e++) begin
            expect6("R9 right held after change", 6'b110110);
            tick();
        end
        expect6("R9 right settle over", 6'b110011);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule